// File: doc/BRIEF.md
# Lane-Confined Byte Shifter

This unit moves whole bytes inside each 128-bit lane of a wide operand. The operand is split into lanes that do not interact. Every lane is shifted by the same byte count, toward higher byte positions (left) or toward lower byte positions (right). The byte positions left empty are filled with zero. No byte ever leaves its lane.

When the count is at or above the number of bytes in a lane, the whole result is zero. A count of zero passes the operand through unchanged.

The datapath is a log-depth byte barrel per lane. An optional output register follows it and carries a valid flag. With the default parameters the result is registered. A sample presented with `in_valid` high appears one clock later, with `out_valid` high. A cycle without `in_valid` leaves the held result as it is.

Top module: `lane_byte_shifter`

## Requirements
- R1: Every 128-bit lane is shifted by the same byte count, and the result of each lane depends only on that lane's own input bytes.
- R2: With `shift_right` = 0 (left), result byte k of a lane equals input byte k−n of the same lane, where byte 0 is bits [7:0] of the lane and n is `byte_count`. Positions k < n are zero.
- R3: With `shift_right` = 1 (right), result byte k of a lane equals input byte k+n of the same lane. Positions k > 15−n are zero.
- R4: Every `byte_count` from 16 to 255 gives an all-zero result in both directions.
- R5: A `byte_count` of 0 returns the operand unchanged in both directions.
- R6: A lane whose input is all zero yields an all-zero output lane, whatever the other lane holds, the direction or the count.
- R7: After reset `out_valid` is 0 and `result` is zero. A sample taken with `in_valid` high appears on `result` with `out_valid` high on the next clock. Without `in_valid`, `out_valid` is 0 on the next clock.
- R8: While `in_valid` is low, `result` holds its last value, whatever the operand, count or direction inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample the current operand, count and direction |
| shift_right | input | 1 | 0 = shift toward higher bytes, 1 = toward lower bytes |
| byte_count | input | 8 | Unsigned shift distance in bytes |
| operand | input | 256 | Data to shift, two 128-bit lanes |
| out_valid | output | 1 | Result register holds a fresh sample |
| result | output | 256 | Shifted data |

## Verification
With the output register in place, every result is due exactly one rising edge after the edge that sampled `in_valid`. Hold behaviour is due on that same edge.

The bench drives inputs on the falling edge. It then waits one full clock and compares on the next falling edge. At that point the registered outputs are settled and the next inputs have not yet been applied.

The bench model advances once per clock: it loads a new expected value when `in_valid` was high and keeps the old one otherwise. Output and model are therefore compared on every cycle, including idle ones.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  localparam int LANE_BITS  = 128;
  localparam int LANE_BYTES = LANE_BITS / 8;
  localparam int SEL_W      = $clog2(LANE_BYTES);

  typedef logic [LANE_BITS-1:0] lane_t;

  // One barrel stage: move the lane by nbytes when enabled.
  function automatic lane_t step_shift(lane_t d, logic en, logic right,
                                       int unsigned nbytes);
    if (!en) return d;
    return right ? (d >> (8 * nbytes)) : (d << (8 * nbytes));
  endfunction

  // A count that reaches past the lane empties it entirely.
  function automatic logic count_saturates(logic [7:0] cnt);
    return (cnt >> SEL_W) != 8'd0;
  endfunction

endpackage

// File: rtl/lbs_lane.sv
module lbs_lane
  import lbs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  lane_t            lane_in,
  input  logic [CNT_W-1:0] cnt,
  input  logic             right,
  input  logic             sat,
  output lane_t            lane_out
);

  lane_t stg [SEL_W+1];

  assign stg[0] = lane_in;

  for (genvar s = 0; s < SEL_W; s++) begin : g_stage
    localparam int unsigned STEP = 1 << s;
    assign stg[s+1] = step_shift(stg[s], cnt[s], right, STEP);
  end

  assign lane_out = sat ? '0 : stg[SEL_W];

endmodule

// File: rtl/lbs_out_stage.sv
module lbs_out_stage #(
  parameter int W       = 256,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_valid <= 1'b0;
        q       <= '0;
      end else begin
        q_valid <= in_valid;
        if (in_valid) q <= d;
      end
    end
  end else begin : g_comb
    assign q_valid = in_valid;
    assign q       = d;
  end

endmodule

// File: rtl/lane_byte_shifter.sv
module lane_byte_shifter
  import lbs_pkg::*;
#(
  parameter int  LANES   = 2,
  parameter int  CNT_W   = 8,
  parameter bit  OUT_REG = 1'b1,
  localparam int DATA_W  = LANES * LANE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              shift_right,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [DATA_W-1:0] operand,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);

  // Named internal events, observed by the bound checker.
  logic              sat_hit;
  logic              pass_thru;
  logic [DATA_W-1:0] shifted;

  assign sat_hit   = count_saturates(8'(byte_count)) | ((byte_count >> 8) != '0);
  assign pass_thru = (byte_count == '0);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lbs_lane #(.CNT_W(CNT_W)) u_lane (
      .lane_in  (operand[l*LANE_BITS +: LANE_BITS]),
      .cnt      (byte_count),
      .right    (shift_right),
      .sat      (sat_hit),
      .lane_out (shifted[l*LANE_BITS +: LANE_BITS])
    );
  end

  lbs_out_stage #(.W(DATA_W), .OUT_REG(OUT_REG)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .d        (shifted),
    .q_valid  (out_valid),
    .q        (result)
  );

endmodule

// File: rtl/lbs_checker.sv
module lbs_checker
  import lbs_pkg::*;
#(
  parameter int LANES   = 2,
  parameter int CNT_W   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       shift_right,
  input logic [CNT_W-1:0]           byte_count,
  input logic [LANES*LANE_BITS-1:0] operand,
  input logic                       out_valid,
  input logic [LANES*LANE_BITS-1:0] result,
  input logic                       sat_hit,
  input logic                       pass_thru
);

  if (OUT_REG) begin : g_seq
    assert_big_count_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && byte_count >= CNT_W'(LANE_BYTES)) |=> (result == '0));

    assert_sat_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sat_hit) |=> (result == '0));

    assert_zero_count_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pass_thru) |=> (result == $past(operand)));

    assert_low_lane_isolated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && operand[LANE_BITS-1:0] == '0) |=> (result[LANE_BITS-1:0] == '0));

    assert_high_lane_isolated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && operand[2*LANE_BITS-1:LANE_BITS] == '0)
        |=> (result[2*LANE_BITS-1:LANE_BITS] == '0));

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

    assert_valid_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));
  end else begin : g_comb
    always_comb begin
      if (in_valid && sat_hit)
        assert_comb_zero_R4: assert (result == '0);
      if (in_valid && pass_thru)
        assert_comb_pass_R5: assert (result == operand);
    end
  end

endmodule

bind lane_byte_shifter lbs_checker #(
  .LANES(LANES), .CNT_W(CNT_W), .OUT_REG(OUT_REG)
) u_lbs_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .shift_right(shift_right),
  .byte_count(byte_count), .operand(operand), .out_valid(out_valid),
  .result(result), .sat_hit(sat_hit), .pass_thru(pass_thru)
);

// File: tb/tb_lane_byte_shifter.sv
`timescale 1ns/1ps
module tb_lane_byte_shifter;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         shift_right = 1'b0;
  logic [7:0]   byte_count = 8'd0;
  logic [255:0] operand = '0;
  logic         out_valid;
  logic [255:0] result;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [255:0] exp_result = '0;

  always #2.5 clk = ~clk;

  lane_byte_shifter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .shift_right(shift_right),
    .byte_count(byte_count), .operand(operand),
    .out_valid(out_valid), .result(result)
  );

  // Byte-by-byte model: each lane of 16 bytes handled on its own.
  function automatic logic [255:0] model(logic [255:0] op, bit right, int n);
    logic [255:0] r = '0;
    for (int l = 0; l < 2; l++) begin
      for (int b = 0; b < 16; b++) begin
        int src = right ? b + n : b - n;
        if (n < 16 && src >= 0 && src < 16)
          r[l*128 + b*8 +: 8] = op[l*128 + src*8 +: 8];
      end
    end
    return r;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check_res(string req, logic [255:0] exp);
    tests++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s result actual=%h expected=%h", req, result, exp);
    end
  endtask

  task automatic check_vld(string req, logic exp);
    tests++;
    if (out_valid !== exp) begin
      fails++;
      $display("FAIL %s out_valid actual=%b expected=%b", req, out_valid, exp);
    end
  endtask

  // Drive on the falling edge and compare one full clock later.
  task automatic cycle(string req, bit v, bit right, int n, logic [255:0] op);
    in_valid    = v;
    shift_right = right;
    byte_count  = 8'(n);
    operand     = op;
    @(negedge clk);
    if (v) exp_result = model(op, right, n);
    check_vld("R7", v);
    check_res(req, exp_result);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check_vld("R7", 1'b0);
    check_res("R7", '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: distinct lanes, both directions
    begin
      logic [255:0] a = rnd256();
      cycle("R1", 1, 0, 3, a);
      cycle("R1", 1, 1, 5, a);
      cycle("R1", 1, 0, 15, a);
      cycle("R1", 1, 1, 15, a);
    end

    // R6: one lane empty, the other full of ones
    cycle("R6", 1, 0, 7, {128'd0, {128{1'b1}}});
    cycle("R6", 1, 1, 7, {{128{1'b1}}, 128'd0});
    cycle("R6", 1, 0, 1, {128'd0, {128{1'b1}}});

    // R8: idle cycles with changing inputs must not disturb the result
    cycle("R8", 0, 1, 0, rnd256());
    cycle("R8", 0, 0, 2, rnd256());

    // Sweep every count in both directions with random operands
    for (int d = 0; d < 2; d++) begin
      for (int n = 0; n < 256; n++) begin
        string tag = (n == 0) ? "R5" : (n > 15) ? "R4" : (d == 1) ? "R3" : "R2";
        cycle(tag, 1, d[0], n, rnd256());
      end
    end

    // R8 again after the sweep, then a final R5 pass-through
    cycle("R8", 0, 0, 0, '1);
    cycle("R5", 1, 1, 0, rnd256());

    done = 1'b1;
    finish_run();
  end

endmodule